// File: doc/BRIEF.md
# Two-Register Phase-Sequenced Processor Core

This block is a tiny 8-bit processor core with two general registers, a program counter and one internal bus. Every instruction moves through a 2-bit phase count: phase 0 presents the PC to memory, phase 1 captures the opcode byte, phase 2 captures a second byte or executes a one-byte instruction, and phase 3 executes a two-byte instruction. One-byte instructions return the count to phase 0 after phase 2 and never reach phase 3.

Program memory has a synchronous read port. The byte at the address on `mem_addr` appears on `mem_rdata` one clock later. A keypad byte with a valid flag feeds the input instruction. A display byte with a one-clock strobe carries the output instruction's result. A branch compares the two registers by XOR and jumps only when they match.

Top module: `duo_reg_core`

## Requirements
- R1: While reset is low and at release, `mem_addr` is 0, `disp_data` is 0, and `disp_strobe` and `halted` are low. Both registers and the PC are zero.
- R2: A one-byte instruction takes 3 clocks and advances the PC by 1. A two-byte instruction takes 4 clocks and advances the PC by 2. From reset release, a load-immediate followed by an output raises the strobe right after the 7th rising edge.
- R3: Opcode byte layout: bits [7:4] are the opcode and bit [0] selects the register S (0 selects R0, 1 selects R1). The other register is O. Load immediate 0x1 is two bytes and writes the second byte into S.
- R4: Add (0x3) writes S+O into S and subtract (0x4) writes S-O into S, both modulo 256.
- R5: Move (0x2) copies O into S.
- R6: Branch-if-equal (0x7, two bytes) loads the PC with the second byte when R0 XOR R1 is zero. Otherwise execution continues after the instruction.
- R7: Jump (0x8, two bytes) always loads the PC with the second byte.
- R8: Input (0x5) holds in its execute phase, with the PC unchanged and no strobe, until `key_valid` is high. It then writes `key_data` into S.
- R9: Output (0x6) drives S onto `disp_data` and raises `disp_strobe` for exactly one clock.
- R10: Halt (0xF) raises `halted` 3 clocks after its fetch starts. From then until reset, the PC (`mem_addr`) and the phase count stay frozen.
- R11: Exactly one internal bus source enable is high in every cycle. The bus is the OR of all sources after each unselected source is forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | Program memory read address (the PC) |
| mem_rdata | input | 8 | Memory byte for the address presented one clock earlier |
| key_data | input | 8 | Keypad buffer byte |
| key_valid | input | 1 | Keypad byte is ready |
| disp_data | output | 8 | Display byte, held between writes |
| disp_strobe | output | 1 | One-clock pulse on each display write |
| halted | output | 1 | Core has stopped on a halt instruction |

## Verification
A wrong phase count shows up first on `mem_addr`, within one clock. The address either advances on a cycle where it should hold or stalls where it should move, which shifts the cycle of every later strobe. A corrupted register or a wrong bus selection stays hidden until the next output instruction. At that point `disp_data` carries the wrong byte, or a branch takes the wrong path and changes how many strobes appear. Each program therefore ends in outputs whose count, values and first-strobe cycle expose the fault within a few instructions.

// File: rtl/duo_reg_core.sv
`timescale 1ns/1ps
module duo_reg_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  input  logic [W-1:0] mem_rdata,
  input  logic [W-1:0] key_data,
  input  logic         key_valid,
  output logic [W-1:0] disp_data,
  output logic         disp_strobe,
  output logic         halted
);
  localparam int NSRC = 5;
  localparam logic [3:0] OP_LDI = 4'h1, OP_MOV = 4'h2, OP_ADD = 4'h3, OP_SUB = 4'h4,
                         OP_IN  = 4'h5, OP_OUT = 4'h6, OP_BEQ = 4'h7, OP_JMP = 4'h8,
                         OP_HLT = 4'hF;

  logic [1:0]      phase;
  logic [W-1:0]    pc, opnd, r0, r1;
  logic [3:0]      op;
  logic            sel;
  logic [NSRC-1:0] en;
  logic [W-1:0]    src [NSRC];
  logic [W-1:0]    bus;
  logic            unused_bits;

  function automatic logic is_long(input logic [3:0] code);
    return code == OP_LDI || code == OP_BEQ || code == OP_JMP;
  endfunction

  assign unused_bits = ^mem_rdata[3:1];
  assign mem_addr = pc;

  wire [W-1:0] rs  = sel ? r1 : r0;
  wire [W-1:0] ro  = sel ? r0 : r1;
  wire [W-1:0] alu = (op == OP_SUB) ? rs - ro : rs + ro;

  wire ex_short = !halted && phase == 2'd2 && !is_long(op);
  wire ex_long  = !halted && phase == 2'd3;
  wire stall    = ex_short && op == OP_IN && !key_valid;
  wire equal    = (r0 ^ r1) == '0;
  wire pc_load  = ex_long && (op == OP_JMP || (op == OP_BEQ && equal));
  wire reg_wr   = (ex_short && (op == OP_MOV || op == OP_ADD || op == OP_SUB ||
                                (op == OP_IN && key_valid)))
                || (ex_long && op == OP_LDI);

  always_comb begin
    case (op)
      OP_MOV:                 en = 5'b00010;
      OP_ADD, OP_SUB:         en = 5'b00100;
      OP_IN:                  en = 5'b01000;
      OP_LDI, OP_BEQ, OP_JMP: en = 5'b10000;
      default:                en = 5'b00001;
    endcase
  end

  assign src[0] = rs;
  assign src[1] = ro;
  assign src[2] = alu;
  assign src[3] = key_data;
  assign src[4] = opnd;

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | ({W{en[i]}} & src[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      pc     <= '0;
      op     <= '0;
      sel    <= 1'b0;
      opnd   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      case (phase)
        2'd0: begin
          pc    <= pc + 1'b1;
          phase <= 2'd1;
        end
        2'd1: begin
          op    <= mem_rdata[7:4];
          sel   <= mem_rdata[0];
          if (is_long(mem_rdata[7:4])) pc <= pc + 1'b1;
          phase <= 2'd2;
        end
        2'd2: begin
          if (is_long(op)) begin
            opnd  <= mem_rdata;
            phase <= 2'd3;
          end else if (op == OP_HLT) begin
            halted <= 1'b1;
          end else if (!stall) begin
            phase <= 2'd0;
          end
        end
        default: begin
          if (pc_load) pc <= bus;
          phase <= 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r0 <= '0;
      r1 <= '0;
    end else if (reg_wr) begin
      if (sel) r1 <= bus;
      else     r0 <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      disp_data   <= '0;
      disp_strobe <= 1'b0;
    end else begin
      disp_strobe <= 1'b0;
      if (ex_short && op == OP_OUT) begin
        disp_data   <= bus;
        disp_strobe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/duo_reg_core_chk.sv
`timescale 1ns/1ps
module duo_reg_core_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   phase,
  input logic [4:0]   en,
  input logic [W-1:0] pc,
  input logic [3:0]   op,
  input logic         halted,
  input logic         disp_strobe,
  input logic         key_valid
);
  p_bus_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en) == 1);

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_strobe |=> !disp_strobe);

  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(phase));

  p_long_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !halted) |=> phase == 2'd0);

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !halted) |=> pc == W'($past(pc) + 1'b1));

  p_input_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && op == 4'h5 && !key_valid && !halted) |=> phase == 2'd2 && $stable(pc));
endmodule

bind duo_reg_core duo_reg_core_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .en(en), .pc(pc), .op(op),
  .halted(halted), .disp_strobe(disp_strobe), .key_valid(key_valid)
);

// File: tb/test_duo_reg_core.sv
`timescale 1ns/1ps
module test_duo_reg_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_rdata, key_data, disp_data;
  logic       key_valid = 1'b0;
  logic       disp_strobe, halted;
  logic [7:0] mem [256];
  logic [7:0] outs [16];
  int         nout, first_cyc, cyc;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  duo_reg_core i_duo_reg_core (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .key_data(key_data), .key_valid(key_valid), .disp_data(disp_data),
    .disp_strobe(disp_strobe), .halted(halted)
  );

  always_ff @(posedge clk) mem_rdata <= mem[mem_addr];

  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  always @(negedge clk) begin
    if (rst_n && disp_strobe) begin
      if (nout == 0) first_cyc = cyc;
      if (nout < 16) outs[nout] = disp_data;
      nout = nout + 1;
    end
  end

  localparam logic [15:0] VEC [6] = '{16'h0305, 16'h0700, 16'hFF01, 16'h0001, 16'h8080, 16'h2A2A};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hF0;
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    nout = 0;
    first_cyc = -1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    key_data = 8'h00;
    nout = 0;
    cyc = 0;
    clear_mem();
    repeat (3) @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] a, b, d, last;
      a = VEC[v][15:8];
      b = VEC[v][7:0];
      d = a - b;
      last = (b == 8'h00) ? d : 8'h5A;
      clear_mem();
      mem[0] = 8'h10; mem[1] = a;
      mem[2] = 8'h11; mem[3] = b;
      mem[4] = 8'h30; mem[5] = 8'h60;
      mem[6] = 8'h10; mem[7] = a;
      mem[8] = 8'h40; mem[9] = 8'h60;
      mem[10] = 8'h21; mem[11] = 8'h61;
      mem[12] = 8'h10; mem[13] = a;
      mem[14] = 8'h70; mem[15] = 8'h14;
      mem[16] = 8'h11; mem[17] = 8'h5A;
      mem[18] = 8'h61; mem[19] = 8'hF0;
      mem[20] = 8'h61; mem[21] = 8'hF0;
      restart();
      run(80);
      chk("R9 output count", nout, 4);
      chk("R4 add wraps", outs[0], 8'(a + b));
      chk("R4 sub wraps", outs[1], d);
      chk("R5 move O to S", outs[2], d);
      chk("R6 branch on equal", outs[3], last);
      chk("R10 halted after program", halted, 1);
      chk("R6 halt address", mem_addr, (b == 8'h00) ? 22 : 20);
    end

    clear_mem();
    mem[0] = 8'hF0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 addr in reset", mem_addr, 0);
    chk("R1 strobe in reset", disp_strobe, 0);
    chk("R1 display in reset", disp_data, 0);
    chk("R1 halted in reset", halted, 0);
    nout = 0;
    rst_n = 1'b1;
    run(2);
    chk("R2 not halted before phase 2 edge", halted, 0);
    run(1);
    chk("R10 halted after 3 clocks", halted, 1);
    chk("R2 one-byte pc step", mem_addr, 1);
    run(10);
    chk("R10 pc frozen", mem_addr, 1);
    chk("R10 still halted", halted, 1);

    clear_mem();
    mem[0] = 8'h10; mem[1] = 8'h11; mem[2] = 8'h60;
    restart();
    run(20);
    chk("R2 first strobe cycle", first_cyc, 7);
    chk("R3 load immediate R0", outs[0], 8'h11);
    chk("R2 two-byte pc step", mem_addr, 4);

    clear_mem();
    mem[0] = 8'h51; mem[1] = 8'h61;
    key_valid = 1'b0;
    key_data = 8'hC3;
    restart();
    run(30);
    chk("R8 no strobe while waiting", nout, 0);
    chk("R8 pc held while waiting", mem_addr, 1);
    key_valid = 1'b1;
    run(1);
    key_valid = 1'b0;
    run(10);
    chk("R8 keypad byte into R1", outs[0], 8'hC3);
    chk("R9 single pulse for input test", nout, 1);

    clear_mem();
    mem[0] = 8'h80; mem[1] = 8'h05; mem[2] = 8'h61;
    mem[5] = 8'h10; mem[6] = 8'h77; mem[7] = 8'h60;
    restart();
    run(40);
    chk("R7 jump skips output", nout, 1);
    chk("R7 jump target value", outs[0], 8'h77);
    chk("R9 display held", disp_data, 8'h77);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule